// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a parameterised cache that sits between a byte-wide load/store requester and a memory port that moves whole blocks. It holds `2**SET_W` sets of `WAYS` lines. Each line has a valid flag, a dirty flag, a tag and a block of `2**OFF_W` bytes. A request is looked up in one set. A hit is answered one cycle later. On a miss the requester is stalled while a victim line is chosen, written back if it is dirty, and refilled from memory. The original request is then completed as a hit.

Writes use write-back with write-allocate. A write hit only updates the cached byte and marks the line dirty. A write miss first brings the block in and then merges the byte into it. Victims are chosen per set: an empty way is taken first, and otherwise the least recently used way is replaced. With `WAYS = 1` the cache is direct mapped and makes a single tag compare per access.

The requester raises `req_i` with a stable `we_i`, `addr_i` and `wdata_i`. It holds them until `ready_o` pulses, and must lower `req_i` on the cycle it sees that pulse. The memory side uses a request/ready handshake. The controller holds `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` steady until memory answers with a one-cycle `mem_ready_i`.

Top module: `wb_cache`

## Requirements
- R1: A byte address is split into three fields. The block offset is bits `[OFF_W-1:0]`, the set index is the `SET_W` bits directly above the offset, and the tag is the remaining upper bits. The memory block address is `addr_i >> OFF_W`. Byte k of a block sits in bits `[8k+7:8k]` of `mem_rdata_i` and `mem_wdata_o`.
- R2: An access hits only when a line in the selected set is valid and its tag equals the address tag. Every way is compared in parallel, and at most one way may hit.
- R3: A read hit returns the byte at the block offset on `rdata_o` with `hit_o=1`. It does so by pulsing `ready_o` one cycle after `req_i` is raised.
- R4: A write hit stores `wdata_i` into the addressed byte, leaves the other bytes of the block unchanged, and marks the line dirty. It completes in one cycle.
- R5: A miss whose victim is clean makes one block read from memory. The requester is then answered with `hit_o=0` and the correct byte. With a memory that answers 2 cycles after it first sees a request, this takes 5 cycles.
- R6: If the victim line is dirty, its block is first written to memory at the victim's own block address, and only then is the new block fetched. With the same 2-cycle memory, this takes 8 cycles.
- R7: A write miss allocates the line. The block is fetched, then the byte is merged into it, and the other bytes of the block keep their memory values.
- R8: The victim is the lowest-numbered invalid way of the set if one exists. Otherwise it is the least recently used way, where every hit and every fill counts as a use.
- R9: Reset clears every valid and dirty flag, so the first access to any block after reset misses. During reset `ready_o` and `mem_req_o` are low.
- R10: With 4-bit addresses, 2-byte blocks, 2 sets and 2 ways, starting cold, the read trace 0, 1, 7, 8, 0 gives miss, hit, miss, miss, hit.
- R11: With 4-bit addresses, 2-byte blocks, 4 sets and 1 way (direct mapped), the same trace gives miss, hit, miss, miss, miss.
- R12: `ready_o` is high for exactly one cycle per request, and the memory port is idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = byte write, 0 = byte read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, valid with `ready_o` |
| hit_o | output | 1 | 1 if the access hit on its first lookup, valid with `ready_o` |
| mem_req_o | output | 1 | Memory block transfer request |
| mem_we_o | output | 1 | 1 = write-back, 0 = fill |
| mem_addr_o | output | ADDR_W-OFF_W | Block address |
| mem_wdata_o | output | 8*2**OFF_W | Block written back |
| mem_ready_i | input | 1 | Memory completion pulse |
| mem_rdata_i | input | 8*2**OFF_W | Block read from memory |

## Verification
Each access is driven on a falling edge, and the bench then counts falling edges until `ready_o` is seen. Hits are therefore expected after 1 cycle, clean misses after 5 and dirty misses after 8, with the bench memory answering 2 cycles after it first sees a request. The returned byte and `hit_o` are sampled on the falling edge where `ready_o` is first high, and `req_i` is dropped on that same edge. The contents of a written-back block are read from the bench memory model once the following access has completed.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } cache_state_e;
endpackage

// File: rtl/wb_cache_lookup.sv
module wb_cache_lookup #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [TAG_W-1:0] tags_i [WAYS],
  input  logic [IDX_W-1:0] ages_i [WAYS],
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_way_o,
  output logic [IDX_W-1:0] victim_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = IDX_W'(w);
  end

  // lowest invalid way wins; else the oldest way
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (ages_i[w] == IDX_W'(WAYS - 1)) victim_o = IDX_W'(w);
    for (int w = 0; w < WAYS; w++)
      if (!valid_i[w] && !found) begin
        victim_o = IDX_W'(w);
        found    = 1'b1;
      end
  end

  p_hit_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_victim_prefers_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~valid_i != '0) |-> !valid_i[victim_o]);
endmodule

// File: rtl/wb_cache_lru.sv
module wb_cache_lru #(
  parameter int WAYS = 2,
  parameter int SETS = 4,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [IDX_W-1:0] way_i,
  output logic [IDX_W-1:0] ages_o [WAYS]
);
  // per-line age: 0 = most recent, WAYS-1 = least recent
  logic [IDX_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= IDX_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (IDX_W'(w) == way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb
    for (int w = 0; w < WAYS; w++) ages_o[w] = age_q[set_i][w];

  p_touched_is_newest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (age_q[$past(set_i)][$past(way_i)] == '0));
endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 2,
  parameter int SET_W  = 2,
  parameter int WAYS   = 2,
  localparam int BLK_W   = 8 << OFF_W,
  localparam int SETS    = 1 << SET_W,
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W,
  localparam int BADDR_W = ADDR_W - OFF_W,
  localparam int IDX_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  output logic               ready_o,
  output logic [7:0]         rdata_o,
  output logic               hit_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [BADDR_W-1:0] mem_addr_o,
  output logic [BLK_W-1:0]   mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic [BLK_W-1:0]   mem_rdata_i
);
  cache_state_e     state_q;
  logic             ready_q, hit_q, miss_q;
  logic [7:0]       rdata_q;
  logic [IDX_W-1:0] vic_q;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [BLK_W-1:0] data_q  [SETS][WAYS];

  // address fields
  logic [OFF_W-1:0] off;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [OFF_W+2:0] bsel;
  assign off     = addr_i[OFF_W-1:0];
  assign set_idx = addr_i[OFF_W +: SET_W];
  assign tag     = addr_i[ADDR_W-1 -: TAG_W];
  assign bsel    = {off, 3'b000};

  logic [TAG_W-1:0] set_tags [WAYS];
  logic [IDX_W-1:0] ages     [WAYS];
  logic             lk_hit;
  logic [IDX_W-1:0] hit_way, victim;
  logic             accept, fill_done;

  always_comb
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[set_idx][w];

  assign accept    = req_i && !ready_q && (state_q == ST_IDLE);
  assign fill_done = (state_q == ST_FILL) && mem_ready_i;

  wb_cache_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_q[set_idx]),
    .tags_i    (set_tags),
    .ages_i    (ages),
    .tag_i     (tag),
    .hit_o     (lk_hit),
    .hit_way_o (hit_way),
    .victim_o  (victim)
  );

  wb_cache_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .touch_i ((accept && lk_hit) || fill_done),
    .set_i   (set_idx),
    .way_i   (fill_done ? vic_q : hit_way),
    .ages_o  (ages)
  );

  // control and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      rdata_q <= '0;
      vic_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (lk_hit) begin
            ready_q <= 1'b1;
            hit_q   <= !miss_q;
            miss_q  <= 1'b0;
            rdata_q <= data_q[set_idx][hit_way][bsel +: 8];
            if (we_i) dirty_q[set_idx][hit_way] <= 1'b1;
          end else begin
            miss_q  <= 1'b1;
            vic_q   <= victim;
            state_q <= (valid_q[set_idx][victim] && dirty_q[set_idx][victim])
                       ? ST_WB : ST_FILL;
          end
        end
        ST_WB: if (mem_ready_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ready_i) begin
          valid_q[set_idx][vic_q] <= 1'b1;
          dirty_q[set_idx][vic_q] <= 1'b0;
          state_q                 <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage, no reset
  always_ff @(posedge clk_i) begin
    if (accept && lk_hit && we_i)
      data_q[set_idx][hit_way][bsel +: 8] <= wdata_i;
    if (fill_done) begin
      data_q[set_idx][vic_q] <= mem_rdata_i;
      tag_q[set_idx][vic_q]  <= tag;
    end
  end

  assign ready_o     = ready_q;
  assign rdata_o     = rdata_q;
  assign hit_o       = hit_q;
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {tag_q[set_idx][vic_q], set_idx}
                                          : {tag, set_idx};
  assign mem_wdata_o = data_q[set_idx][vic_q];

  p_ready_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_mem_idle_on_resp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  p_wb_then_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB && mem_ready_i) |=> (mem_req_o && !mem_we_o));

  p_fill_makes_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (state_q == ST_IDLE && lk_hit));
endmodule

// File: tb/wb_cache_bench.sv
module wb_cache_mem_model #(
  parameter int BADDR_W = 3,
  parameter int BLK_W   = 16,
  parameter int LAT     = 2
) (
  input  logic               clk_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [BADDR_W-1:0] addr_i,
  input  logic [BLK_W-1:0]   wdata_i,
  output logic               ready_o,
  output logic [BLK_W-1:0]   rdata_o
);
  localparam int NB = BLK_W / 8;
  logic [BLK_W-1:0] mem [1 << BADDR_W];
  int cnt;

  initial begin
    ready_o = 1'b0;
    rdata_o = '0;
    cnt     = 0;
    for (int b = 0; b < (1 << BADDR_W); b++)
      for (int k = 0; k < NB; k++)
        mem[b][8*k +: 8] = 8'((b * NB + k) * 7 + 3);
  end

  always @(posedge clk_i) begin
    if (req_i && !ready_o) begin
      if (cnt == LAT - 1) begin
        cnt     <= 0;
        ready_o <= 1'b1;
        rdata_o <= mem[addr_i];
        if (we_i) mem[addr_i] <= wdata_i;
      end else cnt <= cnt + 1;
    end else ready_o <= 1'b0;
  end
endmodule

module wb_cache_bench;
  localparam int AW = 4;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // associative instance (2 sets x 2 ways) and direct-mapped instance
  logic       a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [3:0] a_addr = 0, b_addr = 0;
  logic [7:0] a_wd = 0, b_wd = 0;
  logic       a_rdy, b_rdy, a_hit, b_hit;
  logic [7:0] a_rd, b_rd;
  logic       am_req, am_we, am_rdy, bm_req, bm_we, bm_rdy;
  logic [2:0] am_addr, bm_addr;
  logic [15:0] am_wd, am_rd, bm_wd, bm_rd;

  wb_cache #(.ADDR_W(AW), .OFF_W(1), .SET_W(1), .WAYS(2)) u_wb_cache (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(a_req), .we_i(a_we), .addr_i(a_addr),
    .wdata_i(a_wd), .ready_o(a_rdy), .rdata_o(a_rd), .hit_o(a_hit),
    .mem_req_o(am_req), .mem_we_o(am_we), .mem_addr_o(am_addr),
    .mem_wdata_o(am_wd), .mem_ready_i(am_rdy), .mem_rdata_i(am_rd));

  wb_cache_mem_model #(.BADDR_W(3), .BLK_W(16), .LAT(2)) u_mem_a (
    .clk_i(clk), .req_i(am_req), .we_i(am_we), .addr_i(am_addr),
    .wdata_i(am_wd), .ready_o(am_rdy), .rdata_o(am_rd));

  wb_cache #(.ADDR_W(AW), .OFF_W(1), .SET_W(2), .WAYS(1)) u_wb_cache_dm (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(b_req), .we_i(b_we), .addr_i(b_addr),
    .wdata_i(b_wd), .ready_o(b_rdy), .rdata_o(b_rd), .hit_o(b_hit),
    .mem_req_o(bm_req), .mem_we_o(bm_we), .mem_addr_o(bm_addr),
    .mem_wdata_o(bm_wd), .mem_ready_i(bm_rdy), .mem_rdata_i(bm_rd));

  wb_cache_mem_model #(.BADDR_W(3), .BLK_W(16), .LAT(2)) u_mem_b (
    .clk_i(clk), .req_i(bm_req), .we_i(bm_we), .addr_i(bm_addr),
    .wdata_i(bm_wd), .ready_o(bm_rdy), .rdata_o(bm_rd));

  function automatic logic [7:0] init_byte(int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one access; counts cycles until ready_o, sampled on falling edges
  task automatic access(input bit dm, input bit we, input int a, input logic [7:0] d,
                        output logic [7:0] rd, output bit hit, output int cyc);
    @(negedge clk);
    if (dm) begin b_req = 1; b_we = we; b_addr = 4'(a); b_wd = d; end
    else    begin a_req = 1; a_we = we; a_addr = 4'(a); a_wd = d; end
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!(dm ? b_rdy : a_rdy) && cyc < 50);
    rd  = dm ? b_rd : a_rd;
    hit = dm ? b_hit : a_hit;
    if (dm) b_req = 0; else a_req = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!a_rdy && !am_req, "R9 reset idle assoc", {a_rdy, am_req}, 0);
    check(!b_rdy && !bm_req, "R9 reset idle dm", {b_rdy, bm_req}, 0);
  endtask

  task automatic run_trace(input bit dm, input string rq, input bit exp_hit [5]);
    int tr [5] = '{0, 1, 7, 8, 0};
    logic [7:0] rd; bit hit; int cyc;
    for (int i = 0; i < 5; i++) begin
      access(dm, 0, tr[i], 8'h00, rd, hit, cyc);
      check(hit == exp_hit[i], $sformatf("%s trace step %0d hit", rq, i), hit, exp_hit[i]);
      check(rd == init_byte(tr[i]), $sformatf("R3 %s step %0d data", rq, i), rd, init_byte(tr[i]));
      check(cyc == (exp_hit[i] ? 1 : 5), $sformatf("R5 %s step %0d latency", rq, i),
            cyc, exp_hit[i] ? 1 : 5);
    end
  endtask

  task automatic t_trace_assoc;
    bit e [5] = '{0, 1, 0, 0, 1};
    run_trace(0, "R10", e);
  endtask

  task automatic t_trace_dm;
    bit e [5] = '{0, 1, 0, 0, 0};
    run_trace(1, "R11", e);
  endtask

  // set 0 holds blocks 0 and 4, block 4 least recent
  task automatic t_writeback;
    logic [7:0] rd; bit hit; int cyc;
    access(0, 1, 1, 8'hA5, rd, hit, cyc);
    check(hit && cyc == 1, "R4 write hit one cycle", cyc, 1);
    access(0, 0, 12, 8'h00, rd, hit, cyc);
    check(!hit && cyc == 5, "R8 LRU clean victim latency", cyc, 5);
    check(rd == init_byte(12), "R1 read byte 12", rd, init_byte(12));
    access(0, 0, 4, 8'h00, rd, hit, cyc);
    check(!hit && cyc == 8, "R6 dirty victim latency", cyc, 8);
    check(rd == init_byte(4), "R6 read byte 4", rd, init_byte(4));
    check(u_mem_a.mem[0][15:8] == 8'hA5, "R6 written-back byte 1", u_mem_a.mem[0][15:8], 8'hA5);
    check(u_mem_a.mem[0][7:0] == init_byte(0), "R6 written-back byte 0",
          u_mem_a.mem[0][7:0], init_byte(0));
    access(0, 0, 1, 8'h00, rd, hit, cyc);
    check(!hit && cyc == 5, "R8 refetch after eviction latency", cyc, 5);
    check(rd == 8'hA5, "R4 merged byte survives eviction", rd, 8'hA5);
  endtask

  // set 1 holds block 3 only; write miss to block 7 must use the empty way
  task automatic t_write_alloc;
    logic [7:0] rd; bit hit; int cyc;
    access(0, 1, 14, 8'h3C, rd, hit, cyc);
    check(!hit && cyc == 5, "R7 write miss allocate latency", cyc, 5);
    access(0, 0, 14, 8'h00, rd, hit, cyc);
    check(hit && rd == 8'h3C, "R7 merged byte read back", rd, 8'h3C);
    access(0, 0, 15, 8'h00, rd, hit, cyc);
    check(hit && rd == init_byte(15), "R7 other byte kept", rd, init_byte(15));
    access(0, 0, 7, 8'h00, rd, hit, cyc);
    check(hit && cyc == 1, "R8 empty way preferred, block 3 kept", hit, 1);
    check(rd == init_byte(7), "R2 block 3 data", rd, init_byte(7));
  endtask

  task automatic t_pulse;
    logic [7:0] rd; bit hit; int cyc;
    access(0, 0, 6, 8'h00, rd, hit, cyc);
    @(negedge clk);
    check(!a_rdy, "R12 ready single cycle", a_rdy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_trace_assoc;
    t_trace_dm;
    t_writeback;
    t_write_alloc;
    t_pulse;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule